// File: doc/BRIEF.md
# Network status LED controller

This block turns three internal PHY status indications (link up, high speed, traffic activity) into three LED drive pins. One 16-bit control word, held in the block and reached through a plain synchronous read/write port, sets how the pins behave. The word holds a blink period code, one output polarity bit per LED and, for each LED, a force enable together with a forced on/off value.

Each LED first gets a logical "on" state. When the LED's force enable is set, that state is the forced value. Otherwise the speed and link LEDs follow their status inputs directly. The activity LED follows a blink phase while activity is present and stays off when it is not. The polarity bit then maps the on state to the pin level. The polarity bits load from strap inputs at reset, and software can overwrite them later. The blink phase comes from a cycle counter whose limits are derived from the `CLK_HZ` parameter, which must be at least 20. The pins are registered, so every pin is glitch-free.

Top module: `led_status_ctrl`

## Requirements
- R1: Control bits 15:11 always read as zero, and writing ones to them changes nothing.
- R2: A write (`reg_wr_en` high at a clock edge) stores `reg_wdata[10:0]`, and `reg_rdata` shows the new value from the following cycle; `reg_rdata` is the stored word without delay.
- R3: During reset the stored word takes rate code 2'b10 in bits 10:9 and polarity bits 8:6 equal to `strap_pol[2:0]`, with bits 5:0 zero; each pin then shows its off level (the inverse of its strap).
- R4: The blink phase starts off after reset and toggles each time one phase duration has elapsed. For rate code 00, 01, 10 and 11 (bits 10:9) that duration is CLK_HZ/20, CLK_HZ/10, CLK_HZ/5 and CLK_HZ/2 cycles, that is 50, 100, 200 and 500 ms.
- R5: A write that changes the rate code restarts the timebase: its count returns to zero and the phase returns to off at that clock edge.
- R6: Bits 8, 7 and 6 give the polarity of the speed, link and activity LEDs. When a bit is 1 the pin equals the on state (active high); when it is 0 the pin is the inverse of the on state.
- R7: Bits 5, 4 and 3 enable forcing for the speed, link and activity LEDs, and bits 2, 1 and 0 give the forced on states. A forced on state still passes through the polarity of R6.
- R8: When not forced, the activity LED's on state is the blink phase while `activity` is high, and off while it is low.
- R9: When not forced, the link LED's on state equals `link_up` and the speed LED's on state equals `speed_high`, with no blinking.
- R10: Each pin shows, one clock after an edge, the value computed from the inputs and the stored word as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_pol | input | 3 | Polarity straps {speed, link, activity}, sampled during reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control word, reserved bits zero |
| link_up | input | 1 | Link-up status |
| speed_high | input | 1 | High-speed status |
| activity | input | 1 | Traffic activity status |
| led_speed | output | 1 | Speed LED pin |
| led_link | output | 1 | Link LED pin |
| led_act | output | 1 | Activity LED pin |

## Verification
The assertions assume that the status inputs and the write strobe change only between clock edges, and that `strap_pol` is stable for the whole reset. The bench drives every input on the falling edge and holds the straps at one value from before reset until after it. It also keeps `CLK_HZ` small, so that every rate code completes several phases and the rate-change restart can be seen in the middle of a phase.

// File: rtl/led_pkg.sv
// Shared types and helpers for the status LED controller.
// Assumes three LEDs, indexed activity=0, link=1, speed=2.
package led_pkg;
    localparam int LED_N     = 3;
    localparam int IDX_ACT   = 0;
    localparam int IDX_LINK  = 1;
    localparam int IDX_SPEED = 2;
    localparam int CFG_W     = 16;

    // Control word layout; bit order inside each 3-bit field follows the LED index.
    typedef struct packed {
        logic [4:0]       rsvd;
        logic [1:0]       rate;
        logic [LED_N-1:0] pol;
        logic [LED_N-1:0] frc_en;
        logic [LED_N-1:0] frc_val;
    } led_cfg_t;

    localparam logic [CFG_W-1:0] WR_MASK = 16'h07FF;

    // Number of clock cycles in one blink phase for a rate code.
    function automatic int unsigned phase_cycles(input logic [1:0] code,
                                                 input int unsigned clk_hz);
        case (code)
            2'b00:   return clk_hz / 20;
            2'b01:   return clk_hz / 10;
            2'b10:   return clk_hz / 5;
            default: return clk_hz / 2;
        endcase
    endfunction
endpackage

// File: rtl/led_cfg_reg.sv
// Control word storage. Loads the polarity field from the straps during
// reset, keeps the reserved bits at zero, and flags writes that change the
// rate code. Assumes the straps are stable while reset is held.
module led_cfg_reg
    import led_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LED_N-1:0] strap_pol,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output led_cfg_t         cfg,
    output logic             rate_restart
);
    led_cfg_t wcfg;

    // Masked view of the incoming write data.
    always_comb wcfg = led_cfg_t'(wdata & WR_MASK);

    // Rate-change detection for the timebase restart.
    always_comb rate_restart = wr_en && (wcfg.rate != cfg.rate);

    // Control word register with strap-derived polarity default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.rsvd    <= '0;
            cfg.rate    <= 2'b10;
            cfg.pol     <= strap_pol;
            cfg.frc_en  <= '0;
            cfg.frc_val <= '0;
        end else if (wr_en) begin
            cfg <= wcfg;
        end
    end
endmodule

// File: rtl/led_blink_timer.sv
// Blink timebase: counts clock cycles up to the selected phase length and
// toggles the phase. A restart clears count and phase. Assumes CLK_HZ >= 20.
module led_blink_timer
    import led_pkg::*;
#(
    parameter int unsigned CLK_HZ = 25_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate,
    input  logic       restart,
    output logic       phase
);
    localparam int unsigned MAX_CYC = CLK_HZ / 2;
    localparam int          CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Terminal count for the current rate code.
    always_comb last = CNT_W'(phase_cycles(rate, CLK_HZ) - 1);

    // Phase counter and phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == last) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/led_out_stage.sv
// Per-LED output: picks forced or normal on state, applies polarity and
// registers the pin. During reset each pin shows its strap-derived off level.
module led_out_stage
    import led_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LED_N-1:0] strap_pol,
    input  logic [LED_N-1:0] normal_on,
    input  led_cfg_t         cfg,
    output logic [LED_N-1:0] pin
);
    for (genvar i = 0; i < LED_N; i++) begin : g_led
        logic on_state;

        // Force mux for this LED.
        always_comb on_state = cfg.frc_en[i] ? cfg.frc_val[i] : normal_on[i];

        // Polarity and pin register for this LED.
        always_ff @(posedge clk) begin
            if (!rst_n) pin[i] <= ~strap_pol[i];
            else        pin[i] <= cfg.pol[i] ~^ on_state;
        end
    end
endmodule

// File: rtl/led_status_ctrl.sv
// Status LED controller top: control word, blink timebase and three
// registered LED pins. Assumes inputs are synchronous to clk.
module led_status_ctrl
    import led_pkg::*;
#(
    parameter int unsigned CLK_HZ = 25_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  strap_pol,
    input  logic        reg_wr_en,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        link_up,
    input  logic        speed_high,
    input  logic        activity,
    output logic        led_speed,
    output logic        led_link,
    output logic        led_act
);
    led_cfg_t         cfg;
    logic             rate_restart;
    logic             blink_phase;
    logic [LED_N-1:0] normal_on;
    logic [LED_N-1:0] pin;

    led_cfg_reg i_cfg (
        .clk(clk), .rst_n(rst_n), .strap_pol(strap_pol),
        .wr_en(reg_wr_en), .wdata(reg_wdata),
        .cfg(cfg), .rate_restart(rate_restart)
    );

    led_blink_timer #(.CLK_HZ(CLK_HZ)) i_timer (
        .clk(clk), .rst_n(rst_n), .rate(cfg.rate),
        .restart(rate_restart), .phase(blink_phase)
    );

    // Normal-operation on states per LED.
    always_comb begin
        normal_on[IDX_SPEED] = speed_high;
        normal_on[IDX_LINK]  = link_up;
        normal_on[IDX_ACT]   = activity && blink_phase;
    end

    led_out_stage i_out (
        .clk(clk), .rst_n(rst_n), .strap_pol(strap_pol),
        .normal_on(normal_on), .cfg(cfg), .pin(pin)
    );

    // Port mapping of the control word and pins.
    always_comb begin
        reg_rdata = cfg;
        led_speed = pin[IDX_SPEED];
        led_link  = pin[IDX_LINK];
        led_act   = pin[IDX_ACT];
    end
endmodule

// File: rtl/led_status_ctrl_chk.sv
// Property checker for led_status_ctrl, attached with bind.
module led_status_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        link_up,
    input logic        speed_high,
    input logic        activity,
    input logic        blink_phase,
    input logic        led_speed,
    input logic        led_link,
    input logic        led_act
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[15:11] == 5'b0); // R1

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> reg_rdata == ($past(reg_wdata) & 16'h07FF)); // R2

    AST_RATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wdata[10:9] != reg_rdata[10:9]) |=> !blink_phase); // R5

    AST_FORCE_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5] |=> led_speed == ($past(reg_rdata[8]) ~^ $past(reg_rdata[2]))); // R7

    AST_LINK_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[4] |=> led_link == ($past(reg_rdata[7]) ~^ $past(link_up))); // R9

    AST_SPEED_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[5] |=> led_speed == ($past(reg_rdata[8]) ~^ $past(speed_high))); // R6

    AST_ACT_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[3] && !activity) |=> led_act == !$past(reg_rdata[6])); // R8
endmodule

bind led_status_ctrl led_status_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .link_up(link_up), .speed_high(speed_high),
    .activity(activity), .blink_phase(blink_phase), .led_speed(led_speed),
    .led_link(led_link), .led_act(led_act)
);

// File: tb/test_led_status_ctrl.sv
`timescale 1ns/1ps
module test_led_status_ctrl;
    localparam int HZ = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  strap = 3'b101;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        link_up = 1'b0, speed_high = 1'b0, activity = 1'b0;
    logic        led_speed, led_link, led_act;

    int    checks = 0;
    int    errors = 0;
    string tag = "R3";

    led_status_ctrl #(.CLK_HZ(HZ)) i_led_status_ctrl (
        .clk(clk), .rst_n(rst_n), .strap_pol(strap), .reg_wr_en(wr_en),
        .reg_wdata(wdata), .reg_rdata(rdata), .link_up(link_up),
        .speed_high(speed_high), .activity(activity), .led_speed(led_speed),
        .led_link(led_link), .led_act(led_act)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference state.
    logic [15:0] m_reg;
    int          m_cnt;
    bit          m_ph;
    logic [2:0]  m_pin;

    function automatic int dur_of(input logic [1:0] c);
        int ms;
        case (c) 2'b00: ms = 50; 2'b01: ms = 100; 2'b10: ms = 200; default: ms = 500; endcase
        return ms * HZ / 1000;
    endfunction

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference update on each edge, compared 1 ns later.
    always @(posedge clk) begin
        bit on_s, on_l, on_a;
        if (!rst_n) begin
            m_reg = {5'b0, 2'b10, strap, 6'b0};
            m_cnt = 0; m_ph = 0; m_pin = ~strap;
        end else begin
            on_s = m_reg[5] ? m_reg[2] : speed_high;
            on_l = m_reg[4] ? m_reg[1] : link_up;
            on_a = m_reg[3] ? m_reg[0] : (activity && m_ph);
            m_pin[2] = m_reg[8] ? on_s : !on_s;
            m_pin[1] = m_reg[7] ? on_l : !on_l;
            m_pin[0] = m_reg[6] ? on_a : !on_a;
            if (wr_en && wdata[10:9] != m_reg[10:9]) begin m_cnt = 0; m_ph = 0; end
            else if (m_cnt == dur_of(m_reg[10:9]) - 1) begin m_cnt = 0; m_ph = !m_ph; end
            else m_cnt++;
            if (wr_en) m_reg = wdata & 16'h07FF;
        end
        #1;
        chk("rdata", rdata, m_reg);
        chk("led_speed", {15'b0, led_speed}, {15'b0, m_pin[2]});
        chk("led_link", {15'b0, led_link}, {15'b0, m_pin[1]});
        chk("led_act", {15'b0, led_act}, {15'b0, m_pin[0]});
    end

    task automatic wr(input logic [15:0] v);
        @(negedge clk); wr_en = 1'b1; wdata = v;
        @(negedge clk); wr_en = 1'b0; wdata = ~v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tag = "R3";
        idle(4);
        @(negedge clk); rst_n = 1'b1;
        chk("reset word", rdata, 16'h0540);
        chk("reset pins", {13'b0, led_speed, led_link, led_act}, 16'h0002);

        tag = "R9";
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); link_up = i[0]; speed_high = i[1];
        end

        tag = "R8";
        activity = 1'b1;
        idle(1000);
        activity = 1'b0; idle(50); activity = 1'b1; idle(300);

        tag = "R5";
        wr({5'b0, 2'b00, 3'b101, 6'b0});
        idle(350);
        wr({5'b0, 2'b00, 3'b101, 6'b0});
        idle(50);

        tag = "R4";
        wr({5'b0, 2'b01, 3'b101, 6'b0});
        idle(700);
        wr({5'b0, 2'b11, 3'b101, 6'b0});
        idle(2200);
        wr({5'b0, 2'b10, 3'b101, 6'b0});
        idle(900);

        tag = "R1";
        wr(16'hF800 | {5'b0, 2'b00, 3'b101, 6'b0});
        idle(20);
        wr(16'hFFFF);
        idle(20);

        tag = "R6";
        for (int p = 0; p < 8; p++) begin
            wr({5'b0, 2'b00, p[2:0], 6'b0});
            for (int i = 0; i < 8; i++) begin
                @(negedge clk); link_up = i[0]; speed_high = i[1]; activity = i[2];
            end
            idle(110);
        end

        tag = "R7";
        for (int v = 0; v < 64; v++) begin
            wr({5'b0, 2'b01, v[5:3], 3'b111, v[2:0]});
            @(negedge clk); link_up = ~link_up; speed_high = v[0]; activity = v[1];
            idle(3);
        end
        wr({5'b0, 2'b00, 3'b000, 3'b010, 3'b101});
        idle(250);

        tag = "R10";
        wr({5'b0, 2'b00, 3'b110, 6'b0});
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); link_up = i[0]; speed_high = i[1]; activity = i[2];
        end

        tag = "R2";
        for (int i = 0; i < 12; i++) begin
            wr(16'h0123 * i[15:0] + 16'h0041);
            idle(5);
        end

        finish_run();
    end
endmodule